// File: doc/BRIEF.md
# Key-Protected Memory-Controller Register Bank

This block holds the 32-bit control and status words of a DRAM controller behind a write lock. A host reaches it through a single-cycle word-addressed port that covers a 4 KiB window. Each write is applied at the clock edge on which select and write enable are both high. Reads are combinational, and the read data is zero while the port is idle or writing.

Word 0 is the lock register. Writing an unlock key or a hard-lock key to it moves a three-state lock. Any other value written there returns the bank to the soft-locked state. In the soft-locked state only the lock register and a fixed set of always-open words accept writes. A hard lock closes every protected word, the lock register included, until the next reset. Three words are filtered on the way in. The configuration word has read-only fields forced to fixed values and carries the RAM-size code, which comes from an elaboration-time parameter. The PHY status word can never report busy. The memory-test control word always reports that the test finished and never reports a failure. Every write that the lock throws away raises a one-cycle `write_blocked` pulse.

Top module: `memctl_regbank`

## Requirements
- R1: A write to word 0 (byte 0x00) that the lock allows stores a lock state. 0xFC600309 gives the open state, which reads back as 0x00000001. 0xDEADDEAD gives the hard state, which reads back as 0x00000010. Any other value gives the soft state, which reads back as 0x00000000.
- R2: In the soft state a write to any protected word other than word 0 leaves that word unchanged, and `write_blocked` is high for exactly the cycle after the write edge. Word 0 still accepts writes.
- R3: In the hard state every protected write, including a write to word 0, is discarded and pulses `write_blocked`. Only reset leaves the hard state.
- R4: The words at byte offsets 0x50, 0x6C, 0x74, 0x78, 0x7C, 0x88, 0x8C and 0xB4 store any written value in every lock state and never pulse `write_blocked`.
- R5: A write to the configuration word (byte 0x04) stores the data with bits 31:28, 19:14, 6, 3:2 and 1:0 replaced. Bits 31:28 become 3, bits 3:2 become 3, and bits 1:0 become the RAM-size code. All other bits are taken from the data.
- R6: The RAM-size code is 0, 1, 2 or 3 for `RAM_MIB` = 256, 512, 1024 or 2048. Any other value stops elaboration. With the default of 512 the code is 1.
- R7: A write to the PHY status word (byte 0x60) stores the data with bit 0 cleared and bit 4 set.
- R8: A write to the test-control word (byte 0x70) stores the data with bit 12 set and bit 13 cleared.
- R9: After a synchronous reset the bank is soft-locked, every word reads zero, and the configuration word reads 0x3000000C ORed with the RAM-size code.
- R10: A read at a word address of `NUM_REGS` or above returns zero. A write there changes no word and does not pulse `write_blocked`.
- R11: In the open state a protected word with no filter stores the written data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access select |
| bus_we | input | 1 | Write enable, qualified by `bus_sel` |
| bus_addr | input | ADDR_W (10) | Word address inside the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data, zero when not reading |
| write_blocked | output | 1 | One-cycle pulse after a write that the lock discarded |

## Verification
The assertions take for granted that `bus_sel` and `bus_we` are known after reset and that the address is stable during a write. They also take for granted that every access is a full word, because the port has no byte enables. The stimulus drives every input on the falling edge and holds it for exactly one rising edge before it returns the port to idle. Each write is therefore seen by exactly one edge, and the lock state can change only between accesses.

// File: rtl/memctl_regbank_pkg.sv
// Package: shared types, keys, word indices and filter masks for the
// key-protected register bank. Assumes a 32-bit data path and word addressing.
package memctl_regbank_pkg;

    typedef enum logic [1:0] {
        LK_SOFT = 2'd0,
        LK_OPEN = 2'd1,
        LK_HARD = 2'd2
    } lock_state_t;

    localparam logic [31:0] KEY_OPEN = 32'hFC60_0309;
    localparam logic [31:0] KEY_HARD = 32'hDEAD_DEAD;

    localparam int WORD_KEY  = 0;
    localparam int WORD_CONF = 1;
    localparam int WORD_STAT = 'h18;
    localparam int WORD_TEST = 'h1C;
    localparam int MIN_REGS  = 'h2E;

    // Bits the configuration word keeps from the written data.
    localparam logic [31:0] CONF_KEEP   = ~32'hF00F_C04F;
    localparam logic [31:0] CONF_FORCED = 32'h3000_000C;

    localparam logic [31:0] STAT_CLR = 32'h0000_0001;
    localparam logic [31:0] STAT_SET = 32'h0000_0010;
    localparam logic [31:0] TEST_SET = 32'h0000_1000;
    localparam logic [31:0] TEST_CLR = 32'h0000_2000;

    // Read-back code of each lock state.
    function automatic logic [31:0] lock_code(lock_state_t s);
        case (s)
            LK_OPEN: return 32'h0000_0001;
            LK_HARD: return 32'h0000_0010;
            default: return 32'h0000_0000;
        endcase
    endfunction

    // Words that accept writes regardless of the lock.
    function automatic logic is_open_word(logic [11:0] w);
        case (w)
            12'h014, 12'h01B, 12'h01D, 12'h01E,
            12'h01F, 12'h022, 12'h023, 12'h02D: return 1'b1;
            default:                            return 1'b0;
        endcase
    endfunction

    // Size code for a RAM size in MiB; -1 marks an unsupported size.
    function automatic int ram_code(int mib);
        case (mib)
            256:     return 0;
            512:     return 1;
            1024:    return 2;
            2048:    return 3;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/memctl_lock_fsm.sv
// Lock state machine: holds the soft/open/hard state and decodes key writes.
// Assumes key_wr is raised only for writes that the filter already allowed.
module memctl_lock_fsm
    import memctl_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    output lock_state_t state
);

    lock_state_t next_state;

    // Decode the key value into the requested state.
    always_comb begin
        next_state = state;
        if (key_wr) begin
            if (key_data == KEY_OPEN)      next_state = LK_OPEN;
            else if (key_data == KEY_HARD) next_state = LK_HARD;
            else                           next_state = LK_SOFT;
        end
    end

    // State register; reset leaves the bank soft-locked.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LK_SOFT;
        else        state <= next_state;
    end

    AST_HARD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_HARD) |=> (state == LK_HARD)); // R3

    AST_KEY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(state)); // R1

endmodule

// File: rtl/memctl_wr_filter.sv
// Write filter: decides whether an access may write, routes key writes to the
// lock FSM and applies the per-word forced and masked bits. Pure combinational.
// Assumes NUM_REGS does not exceed the address window.
module memctl_wr_filter
    import memctl_regbank_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int NUM_REGS = 64,
    parameter int IDX_W    = $clog2(NUM_REGS),
    parameter logic [1:0] SIZE_CODE = 2'd1
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  lock_state_t       state,
    output logic              key_wr,
    output logic              reg_wr,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [31:0]       reg_data,
    output logic              blocked
);

    logic in_range, open_w, prot_w, is_key, allowed, wr_req;

    // Classify the address and apply the lock policy.
    always_comb begin
        wr_req   = sel && we;
        in_range = ({{(32-ADDR_W){1'b0}}, addr} < 32'(NUM_REGS));
        open_w   = in_range && is_open_word(12'(addr));
        prot_w   = in_range && !open_w;
        is_key   = (addr == '0);
        allowed  = open_w || (prot_w && ((state == LK_OPEN) ||
                   (is_key && state == LK_SOFT)));
        key_wr   = wr_req && prot_w && is_key && allowed;
        reg_wr   = wr_req && allowed && !is_key;
        blocked  = wr_req && prot_w && !allowed;
        reg_idx  = addr[IDX_W-1:0];
    end

    // Sanitise the data of the filtered words.
    always_comb begin
        reg_data = wdata;
        if (32'(reg_idx) == WORD_CONF)
            reg_data = (wdata & CONF_KEEP) | CONF_FORCED | {30'd0, SIZE_CODE};
        else if (32'(reg_idx) == WORD_STAT)
            reg_data = (wdata & ~STAT_CLR) | STAT_SET;
        else if (32'(reg_idx) == WORD_TEST)
            reg_data = (wdata & ~TEST_CLR) | TEST_SET;
    end

endmodule

// File: rtl/memctl_reg_store.sv
// Register storage: NUM_REGS 32-bit words with one write port and one
// combinational read port. Word 0 is never written here; the lock FSM owns it.
module memctl_reg_store
    import memctl_regbank_pkg::*;
#(
    parameter int NUM_REGS = 64,
    parameter int IDX_W    = $clog2(NUM_REGS),
    parameter logic [31:0] CONF_RESET = 32'h3000_000D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);

    logic [31:0] mem [NUM_REGS];

    // Word storage with synchronous reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++)
                mem[i] <= (i == WORD_CONF) ? CONF_RESET : 32'h0;
        end else if (wr) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Read port.
    assign rd_data = mem[rd_idx];

    AST_CONF_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem[WORD_CONF][31:28] == 4'h3 && mem[WORD_CONF][3:2] == 2'b11)); // R5

    AST_PHY_NEVER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem[WORD_STAT][0] == 1'b0)); // R7

    AST_TEST_NEVER_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem[WORD_TEST][13] == 1'b0)); // R8

endmodule

// File: rtl/memctl_regbank.sv
// Top: key-protected register bank for a DRAM controller. Joins the filter,
// lock FSM and storage, builds the read mux and the write_blocked pulse.
// Assumes full-word accesses only and a RAM_MIB of 256, 512, 1024 or 2048.
module memctl_regbank
    import memctl_regbank_pkg::*;
#(
    parameter int WINDOW_BYTES = 4096,
    parameter int NUM_REGS     = 64,
    parameter int RAM_MIB      = 512
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_sel,
    input  logic                              bus_we,
    input  logic [$clog2(WINDOW_BYTES/4)-1:0] bus_addr,
    input  logic [31:0]                       bus_wdata,
    output logic [31:0]                       bus_rdata,
    output logic                              write_blocked
);

    localparam int ADDR_W    = $clog2(WINDOW_BYTES / 4);
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int RAM_CODE  = ram_code(RAM_MIB);
    localparam logic [1:0] SIZE_CODE = 2'(RAM_CODE);
    localparam logic [31:0] CONF_RESET = CONF_FORCED | {30'd0, SIZE_CODE};

    if (RAM_CODE < 0) begin : g_bad_size
        $error("memctl_regbank: unsupported RAM_MIB");
    end
    if (NUM_REGS < MIN_REGS || NUM_REGS > WINDOW_BYTES / 4) begin : g_bad_depth
        $error("memctl_regbank: NUM_REGS out of range");
    end

    lock_state_t       lock_state;
    logic              key_wr, reg_wr, blocked_now;
    logic [IDX_W-1:0]  reg_idx;
    logic [31:0]       reg_data, store_rd;
    logic              rd_in_range;

    memctl_wr_filter #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .SIZE_CODE(SIZE_CODE)
    ) u_filter (
        .sel(bus_sel), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .state(lock_state), .key_wr(key_wr), .reg_wr(reg_wr),
        .reg_idx(reg_idx), .reg_data(reg_data), .blocked(blocked_now)
    );

    memctl_lock_fsm u_lock (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(bus_wdata),
        .state(lock_state)
    );

    memctl_reg_store #(
        .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CONF_RESET(CONF_RESET)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wr_idx(reg_idx),
        .wr_data(reg_data), .rd_idx(bus_addr[IDX_W-1:0]), .rd_data(store_rd)
    );

    // Register the discarded-write pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) write_blocked <= 1'b0;
        else        write_blocked <= blocked_now;
    end

    // Read mux: lock code at word 0, zero outside the array or when idle.
    always_comb begin
        rd_in_range = ({{(32-ADDR_W){1'b0}}, bus_addr} < 32'(NUM_REGS));
        bus_rdata   = 32'h0;
        if (bus_sel && !bus_we && rd_in_range)
            bus_rdata = (bus_addr == '0) ? lock_code(lock_state) : store_rd;
    end

    AST_SOFT_CONF_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && 32'(bus_addr) == WORD_CONF && lock_state == LK_SOFT)
        |=> write_blocked); // R2

    AST_HARD_KEY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == '0 && lock_state == LK_HARD)
        |=> write_blocked); // R3

    AST_OOR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && 32'(bus_addr) >= NUM_REGS) |=> !write_blocked); // R10

    AST_OPEN_NEVER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && is_open_word(12'(bus_addr))) |=> !write_blocked); // R4

endmodule

// File: tb/memctl_regbank_bench.sv
module memctl_regbank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        write_blocked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    memctl_regbank u_memctl_regbank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .write_blocked(write_blocked)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One write; returns write_blocked as seen in the following cycle.
    task automatic wr(input logic [9:0] a, input logic [31:0] d, output logic blk);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        #1 blk = write_blocked;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        rd(10'h000, d); check("R9 lock after reset", d, 32'h0);
        rd(10'h001, d); check("R9 R6 conf after reset", d, 32'h3000_000D);
        rd(10'h020, d); check("R9 plain word after reset", d, 32'h0);
        rd(10'h018, d); check("R9 status after reset", d, 32'h0);
    endtask

    task automatic t_soft_lock();
        logic b; logic [31:0] d;
        wr(10'h001, 32'hFFFF_FFFF, b); check("R2 conf write blocked pulse", 32'(b), 32'd1);
        #8 check("R2 pulse lasts one cycle", 32'(write_blocked), 32'd0);
        rd(10'h001, d); check("R2 conf unchanged", d, 32'h3000_000D);
        wr(10'h014, 32'hA5A5_1234, b); check("R4 open word not blocked", 32'(b), 32'd0);
        rd(10'h014, d); check("R4 open word 0x50 while soft", d, 32'hA5A5_1234);
        wr(10'h02D, 32'h0BAD_F00D, b);
        rd(10'h02D, d); check("R4 open word 0xB4 while soft", d, 32'h0BAD_F00D);
    endtask

    task automatic t_unlock_and_plain();
        logic b; logic [31:0] d;
        wr(10'h000, 32'hFC60_0309, b); check("R2 key writable while soft", 32'(b), 32'd0);
        rd(10'h000, d); check("R1 open code", d, 32'h1);
        wr(10'h020, 32'h1234_5678, b);
        rd(10'h020, d); check("R11 plain word stored", d, 32'h1234_5678);
    endtask

    task automatic t_conf_filter();
        logic b; logic [31:0] d;
        wr(10'h001, 32'hFFFF_FFFF, b);
        rd(10'h001, d); check("R5 conf all ones", d, 32'h3FF0_3FBD);
        wr(10'h001, 32'h0000_0140, b);
        rd(10'h001, d); check("R5 conf bit6 dropped bit8 kept", d, 32'h3000_010D);
        wr(10'h001, 32'h0000_0000, b);
        rd(10'h001, d); check("R6 conf size code", d, 32'h3000_000D);
    endtask

    task automatic t_status_test();
        logic b; logic [31:0] d;
        wr(10'h018, 32'h0000_0001, b);
        rd(10'h018, d); check("R7 status busy cleared", d, 32'h0000_0010);
        wr(10'h018, 32'hFFFF_FFFF, b);
        rd(10'h018, d); check("R7 status all ones", d, 32'hFFFF_FFFE);
        wr(10'h01C, 32'h0000_2000, b);
        rd(10'h01C, d); check("R8 test fail cleared", d, 32'h0000_1000);
        wr(10'h01C, 32'hFFFF_FFFF, b);
        rd(10'h01C, d); check("R8 test all ones", d, 32'hFFFF_DFFF);
    endtask

    task automatic t_out_of_range();
        logic b; logic [31:0] d;
        wr(10'h100, 32'hDEAD_DEAD, b); check("R10 oor write no pulse", 32'(b), 32'd0);
        rd(10'h100, d); check("R10 oor read zero", d, 32'h0);
        rd(10'h000, d); check("R10 key not aliased", d, 32'h1);
        rd(10'h3FF, d); check("R10 top of window reads zero", d, 32'h0);
    endtask

    task automatic t_relock_soft();
        logic b; logic [31:0] d;
        wr(10'h000, 32'h1234_5678, b);
        rd(10'h000, d); check("R1 other value gives soft", d, 32'h0);
        wr(10'h020, 32'hCAFE_0000, b); check("R2 plain blocked pulse", 32'(b), 32'd1);
        rd(10'h020, d); check("R2 plain unchanged", d, 32'h1234_5678);
        wr(10'h000, 32'hFC60_0309, b);
        rd(10'h000, d); check("R1 reopen from soft", d, 32'h1);
    endtask

    task automatic t_hard_lock();
        logic b; logic [31:0] d;
        wr(10'h000, 32'hDEAD_DEAD, b);
        rd(10'h000, d); check("R1 hard code", d, 32'h10);
        wr(10'h000, 32'hFC60_0309, b); check("R3 key blocked pulse", 32'(b), 32'd1);
        rd(10'h000, d); check("R3 still hard", d, 32'h10);
        wr(10'h020, 32'h0, b); check("R3 plain blocked", 32'(b), 32'd1);
        rd(10'h020, d); check("R3 plain unchanged", d, 32'h1234_5678);
        wr(10'h023, 32'h5555_AAAA, b); check("R4 open word not blocked hard", 32'(b), 32'd0);
        rd(10'h023, d); check("R4 open word 0x8C while hard", d, 32'h5555_AAAA);
        do_reset();
        rd(10'h000, d); check("R9 R3 reset leaves hard", d, 32'h0);
        rd(10'h020, d); check("R9 plain cleared by reset", d, 32'h0);
        rd(10'h023, d); check("R9 open word cleared", d, 32'h0);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_soft_lock();
        t_unlock_and_plain();
        t_conf_filter();
        t_status_test();
        t_out_of_range();
        t_relock_soft();
        t_hard_lock();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule